// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block keeps the programmed mode word of an SDRAM controller and turns each burst request into the sequence of column addresses for that burst. A mode-load strobe captures a 14-bit mode value. It decodes the burst length, the beat ordering, the CAS latency, the operating mode and a write single-access option. A burst-start strobe carries a starting column and a read/write flag. The block then presents one column per beat on a valid/ready output stream. The consumer (the command sequencer) raises `col_ready` when it issues the column.

The output stream follows the usual rules. While `col_valid` is high and `col_ready` is low, `col` and `col_last` hold their values. A beat is consumed on any clock edge where both are high. `col_valid` never depends on `col_ready`. After reset, and after the final beat of a burst, `col_valid` is low until the next accepted start. A terminate input ends a burst at once. A new start restarts address generation even in the middle of a burst. Reserved mode codes raise a sticky flag, and while the flag is set no burst is started.

Top module: `burst_colgen`

## Requirements
- R1: Mode bits 2:0 set the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full-page burst. Reset loads the mode word 0x020, which is 1 beat, sequential order and CAS latency 2. `col_valid` and `illegal_mode` reset low.
- R2: With mode bit 3 = 0 (sequential), the low column bits inside the aligned block of the burst size count up from the start column and wrap to the bottom of the block. For example, length 4 from column 2 gives 2,3,0,1.
- R3: With mode bit 3 = 1 (interleaved), the low block bits of beat i equal the start column's low block bits XOR i. For example, length 8 from 5 gives 5,4,7,6,1,0,3,2.
- R4: Column bits above the burst block keep the value of the start column for the whole burst.
- R5: A full-page burst walks all 9 column bits upward from any start column and wraps from 511 to 0. It never raises `col_last` and runs until it is terminated or restarted.
- R6: With burst length 1, only the start column is issued and mode bit 3 has no effect.
- R7: Mode bits 6:4 give the CAS latency on `cas_latency`: 010 gives 2 and 011 gives 3. Any other code outputs 0.
- R8: When mode bit 9 is 1, every write burst is one beat long. Read bursts keep the programmed length.
- R9: A mode load with a reserved length code (100, 101, 110, or 111 together with bit 3 = 1), a reserved CAS code, or mode bits 8:7 not equal to 00 sets `illegal_mode`. The flag clears only on reset. While the flag is set, burst starts are ignored.
- R10: `col_last` is high with `col_valid` exactly on the final beat of a fixed-length burst. When that beat is consumed, `col_valid` drops on the next cycle.
- R11: While `col_valid` is high and `col_ready` is low, `col` and `col_last` stay stable and the beat is not lost.
- R12: `terminate` makes `col_valid` low on the next cycle. If `burst_start` arrives in the same cycle, the start wins.
- R13: An accepted `burst_start` during an active burst presents the new start column as beat 0 on the next cycle, using the mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_load | input | 1 | Capture `mode_value` into the mode word |
| mode_value | input | 14 | Mode word to load (bits 13:10 carry no function) |
| burst_start | input | 1 | Start a burst at `start_col` |
| burst_write | input | 1 | The started burst is a write (1) or a read (0) |
| start_col | input | 9 | Starting column of the burst |
| terminate | input | 1 | End the current burst |
| col_ready | input | 1 | Consumer takes the presented beat |
| col_valid | output | 1 | A beat column is presented |
| col | output | 9 | Column address of the presented beat |
| col_last | output | 1 | Presented beat is the final one of a fixed-length burst |
| cas_latency | output | 2 | Decoded CAS latency (2, 3, or 0 when reserved) |
| illegal_mode | output | 1 | Sticky flag for a reserved mode code |

## Verification
The hardest case to reach from the ports is the restart: a start that arrives in the same cycle that a mid-burst beat is handshaken. The bench stalls nothing here. It keeps `col_ready` high through an interleaved burst of eight and raises `burst_start` with a different column while beat 3 is shown. The scoreboard then expects old beats 0 to 3 followed by the full new burst. A second hard case is the full-page wrap past column 511. The bench starts a page burst three columns below the top of the row, consumes beats across the wrap, and ends the burst with `terminate`. This proves that `col_last` never rose.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  localparam int CTRL_W = 10;
  localparam int BT_BIT = 3;
  localparam int CL_LSB = 4;
  localparam int OP_LSB = 7;
  localparam int WS_BIT = 9;

  typedef enum logic [2:0] {
    LEN_1    = 3'b000,
    LEN_2    = 3'b001,
    LEN_4    = 3'b010,
    LEN_8    = 3'b011,
    LEN_PAGE = 3'b111
  } len_code_e;

  typedef struct packed {
    logic       full_page;
    logic       interleave;
    logic [1:0] len_log2;
  } burst_cfg_t;

  function automatic logic len_code_bad(logic [2:0] code, logic bt);
    case (code)
      LEN_1, LEN_2, LEN_4, LEN_8: return 1'b0;
      LEN_PAGE:                   return bt;
      default:                    return 1'b1;
    endcase
  endfunction

  function automatic logic [1:0] cas_decode(logic [2:0] code);
    case (code)
      3'b010:  return 2'd2;
      3'b011:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/colgen_mode_reg.sv
module colgen_mode_reg
  import colgen_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_MODE = 10'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] value,
  output burst_cfg_t        cfg_rd,
  output logic              wr_single,
  output logic [1:0]        cas_latency,
  output logic              illegal
);
  logic [CTRL_W-1:0] mode_q;
  logic              illegal_q;
  logic              value_bad;

  always_comb begin
    value_bad = len_code_bad(value[2:0], value[BT_BIT])
              | (cas_decode(value[CL_LSB +: 3]) == 2'd0)
              | (value[OP_LSB +: 2] != 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= RESET_MODE;
      illegal_q <= 1'b0;
    end else if (load) begin
      mode_q    <= value;
      illegal_q <= illegal_q | value_bad;
    end
  end

  always_comb begin
    cfg_rd.full_page  = (mode_q[2:0] == LEN_PAGE);
    cfg_rd.interleave = mode_q[BT_BIT];
    cfg_rd.len_log2   = mode_q[1:0];
  end

  assign wr_single   = mode_q[WS_BIT];
  assign cas_latency = cas_decode(mode_q[CL_LSB +: 3]);
  assign illegal     = illegal_q;
endmodule

// File: rtl/colgen_cfg_pick.sv
module colgen_cfg_pick
  import colgen_pkg::*;
(
  input  burst_cfg_t cfg_rd,
  input  logic       wr_single,
  input  logic       is_write,
  output burst_cfg_t cfg_eff
);
  always_comb begin
    if (is_write && wr_single) begin
      cfg_eff.full_page  = 1'b0;
      cfg_eff.interleave = 1'b0;
      cfg_eff.len_log2   = 2'd0;
    end else begin
      cfg_eff = cfg_rd;
    end
  end
endmodule

// File: rtl/colgen_beat_gen.sv
module colgen_beat_gen
  import colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ok,
  input  burst_cfg_t       cfg_in,
  input  logic [COL_W-1:0] start_col,
  input  logic             terminate,
  input  logic             ready,
  output logic             valid,
  output logic [COL_W-1:0] col,
  output logic             last
);
  logic             valid_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt_q;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] low;

  always_comb begin
    mask = cfg_q.full_page ? {COL_W{1'b1}} : ~({COL_W{1'b1}} << cfg_q.len_log2);
    if (cfg_q.interleave && !cfg_q.full_page) low = base_q ^ cnt_q;
    else                                      low = base_q + cnt_q;
  end

  assign col   = (base_q & ~mask) | (low & mask);
  assign last  = valid_q && !cfg_q.full_page && (cnt_q == mask);
  assign valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      cfg_q   <= '0;
    end else if (start_ok) begin
      valid_q <= 1'b1;
      base_q  <= start_col;
      cnt_q   <= '0;
      cfg_q   <= cfg_in;
    end else if (terminate) begin
      valid_q <= 1'b0;
    end else if (valid_q && ready) begin
      if (last) valid_q <= 1'b0;
      else      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_load,
  input  logic [MODE_W-1:0] mode_value,
  input  logic              burst_start,
  input  logic              burst_write,
  input  logic [COL_W-1:0]  start_col,
  input  logic              terminate,
  input  logic              col_ready,
  output logic              col_valid,
  output logic [COL_W-1:0]  col,
  output logic              col_last,
  output logic [1:0]        cas_latency,
  output logic              illegal_mode
);
  burst_cfg_t cfg_rd;
  burst_cfg_t cfg_eff;
  logic       wr_single;
  logic       unused_hi;

  assign unused_hi = ^mode_value[MODE_W-1:CTRL_W];

  colgen_mode_reg u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (mode_load),
    .value       (mode_value[CTRL_W-1:0]),
    .cfg_rd      (cfg_rd),
    .wr_single   (wr_single),
    .cas_latency (cas_latency),
    .illegal     (illegal_mode)
  );

  colgen_cfg_pick u_pick (
    .cfg_rd    (cfg_rd),
    .wr_single (wr_single),
    .is_write  (burst_write),
    .cfg_eff   (cfg_eff)
  );

  colgen_beat_gen #(.COL_W(COL_W)) u_beat (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (burst_start && !illegal_mode),
    .cfg_in    (cfg_eff),
    .start_col (start_col),
    .terminate (terminate),
    .ready     (col_ready),
    .valid     (col_valid),
    .col       (col),
    .last      (col_last)
  );
endmodule

// File: rtl/burst_colgen_checker.sv
module burst_colgen_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_start,
  input logic [COL_W-1:0] start_col,
  input logic             terminate,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col,
  input logic             col_last,
  input logic [1:0]       cas_latency,
  input logic             illegal_mode
);
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid); // R10
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_last && col_ready && !burst_start |=> !col_valid); // R10
  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode |=> illegal_mode); // R9
  AST_ILLEGAL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_mode && burst_start && !col_valid |=> !col_valid); // R9
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !burst_start && !terminate |=>
      col_valid && $stable(col) && $stable(col_last)); // R11
  AST_TERM_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    terminate && !burst_start |=> !col_valid); // R12
  AST_RESTART_COL: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start && !illegal_mode |=> col_valid && col == $past(start_col)); // R13
  AST_CAS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cas_latency != 2'd1); // R7
endmodule

bind burst_colgen burst_colgen_checker #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .burst_start  (burst_start),
  .start_col    (start_col),
  .terminate    (terminate),
  .col_ready    (col_ready),
  .col_valid    (col_valid),
  .col          (col),
  .col_last     (col_last),
  .cas_latency  (cas_latency),
  .illegal_mode (illegal_mode)
);

// File: tb/burst_colgen_bench.sv
`timescale 1ns/1ps
module burst_colgen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_load = 1'b0;
  logic [13:0] mode_value = '0;
  logic        burst_start = 1'b0;
  logic        burst_write = 1'b0;
  logic [8:0]  start_col = '0;
  logic        terminate = 1'b0;
  logic        col_ready = 1'b0;
  logic        col_valid;
  logic [8:0]  col;
  logic        col_last;
  logic [1:0]  cas_latency;
  logic        illegal_mode;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { int c; bit l; string req; } beat_t;
  beat_t exp_q[$];

  always #2 clk = ~clk;

  burst_colgen u_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_value(mode_value),
    .burst_start(burst_start), .burst_write(burst_write), .start_col(start_col),
    .terminate(terminate), .col_ready(col_ready), .col_valid(col_valid), .col(col),
    .col_last(col_last), .cas_latency(cas_latency), .illegal_mode(illegal_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(int base, int idx, int len, bit inter, bit full);
    int off0;
    int off;
    if (full) return (base + idx) % 512;
    off0 = base % len;
    off  = inter ? (off0 ^ idx) : ((off0 + idx) % len);
    return base - off0 + off;
  endfunction

  // monitor: pops one expected beat per handshake
  always @(negedge clk) begin
    if (rst_n && col_valid && col_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected beat", col, -1);
      end else begin
        beat_t b;
        b = exp_q.pop_front();
        check(col == b.c[8:0], b.req, col, b.c);
        check(col_last == b.l, {b.req, " last"}, col_last, b.l);
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; mode_load = 0; burst_start = 0; terminate = 0; col_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic load_mode(input logic [13:0] m);
    @(posedge clk); #1 mode_load = 1'b1; mode_value = m;
    @(posedge clk); #1 mode_load = 1'b0;
  endtask

  task automatic push(input int sc, input int len, input bit inter, input bit full,
                      input int from, input int cnt, input string req);
    for (int i = from; i < from + cnt; i++) begin
      beat_t b;
      b.c = model(sc, i, len, inter, full);
      b.l = !full && (i == len - 1);
      b.req = req;
      exp_q.push_back(b);
    end
  endtask

  task automatic launch(input bit wr, input int sc);
    @(posedge clk); #1 burst_start = 1'b1; burst_write = wr; start_col = sc[8:0]; col_ready = 1'b1;
    @(posedge clk); #1 burst_start = 1'b0;
  endtask

  task automatic finish_burst(input bit stop, input string req);
    if (stop) begin
      col_ready = 1'b0; terminate = 1'b1;
      @(posedge clk); #1 terminate = 1'b0;
    end else begin
      col_ready = 1'b0;
    end
    check(col_valid == 1'b0, req, col_valid, 0);
    check(exp_q.size() == 0, {req, " queue drained"}, exp_q.size(), 0);
  endtask

  task automatic run_burst(input bit wr, input int sc, input int len, input bit inter,
                           input bit full, input int nbeats, input string req);
    push(sc, len, inter, full, 0, nbeats, req);
    launch(wr, sc);
    repeat (nbeats) @(posedge clk);
    #1 finish_burst(full || nbeats < len, req);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    #1;
    check(col_valid == 0, "R1 reset valid", col_valid, 0);
    check(illegal_mode == 0, "R1 reset illegal", illegal_mode, 0);
    check(cas_latency == 2, "R7 reset CAS", cas_latency, 2);
    run_burst(0, 9'h0C7, 1, 0, 0, 1, "R1 reset mode single beat");

    // R2 R4 sequential length 4, upper bits fixed
    load_mode(14'h0022);
    run_burst(0, 9'h0A6, 4, 0, 0, 4, "R2 R4 seq len4");
    load_mode(14'h0021);
    run_burst(0, 9'h1F3, 2, 0, 0, 2, "R2 seq len2");
    load_mode(14'h0023);
    run_burst(0, 9'h15D, 8, 0, 0, 8, "R2 seq len8");

    // R3 interleaved, R7 CAS 3
    load_mode(14'h003B);
    #1 check(cas_latency == 3, "R7 CAS 3", cas_latency, 3);
    run_burst(0, 9'h0ED, 8, 1, 0, 8, "R3 R4 intl len8");
    load_mode(14'h0029);
    run_burst(0, 9'h101, 2, 1, 0, 2, "R3 intl len2");
    load_mode(14'h002A);
    run_burst(0, 9'h03B, 4, 1, 0, 4, "R3 intl len4");

    // R6 length 1 with bit3 set
    load_mode(14'h0028);
    run_burst(0, 9'h133, 1, 1, 0, 1, "R6 len1 bt ignored");

    // R5 full page wrap, terminated
    load_mode(14'h0037);
    run_burst(0, 509, 512, 0, 1, 7, "R5 page wrap");

    // R8 write single access
    load_mode(14'h0223);
    run_burst(1, 9'h04E, 1, 0, 0, 1, "R8 write single");
    run_burst(0, 9'h04E, 8, 0, 0, 8, "R8 read keeps len");
    load_mode(14'h0023);
    run_burst(1, 9'h04E, 8, 0, 0, 8, "R8 write full len");

    // R12 terminate mid fixed burst
    run_burst(0, 9'h020, 8, 0, 0, 2, "R12 terminate");

    // R11 stall holds beat
    load_mode(14'h0022);
    push(9'h101, 4, 0, 0, 0, 4, "R11 stall");
    launch(0, 9'h101);
    col_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 check(col_valid && col == 9'h101, "R11 held beat", col, 9'h101);
    col_ready = 1'b1;
    repeat (4) @(posedge clk);
    #1 finish_burst(1'b0, "R11 stall");

    // R13 restart mid burst
    load_mode(14'h002B);
    push(9'h0F2, 8, 1, 0, 0, 4, "R13 old burst");
    push(9'h06B, 8, 1, 0, 0, 8, "R13 new burst");
    launch(0, 9'h0F2);
    repeat (3) @(posedge clk);
    #1 burst_start = 1'b1; start_col = 9'h06B;
    @(posedge clk); #1 burst_start = 1'b0;
    repeat (8) @(posedge clk);
    #1 finish_burst(1'b0, "R13 restart");

    // R12 start beats terminate in the same cycle
    load_mode(14'h0022);
    push(9'h011, 4, 0, 0, 0, 4, "R12 start wins");
    @(posedge clk); #1 burst_start = 1'b1; terminate = 1'b1; start_col = 9'h011; col_ready = 1'b1;
    @(posedge clk); #1 burst_start = 1'b0; terminate = 1'b0;
    repeat (4) @(posedge clk);
    #1 finish_burst(1'b0, "R12 start wins");

    // R9 illegal codes
    load_mode(14'h0025);
    #1 check(illegal_mode == 1, "R9 len code 101", illegal_mode, 1);
    load_mode(14'h0022);
    #1 check(illegal_mode == 1, "R9 sticky", illegal_mode, 1);
    @(posedge clk); #1 burst_start = 1'b1; start_col = 9'h010;
    @(posedge clk); #1 burst_start = 1'b0;
    check(col_valid == 0, "R9 start ignored", col_valid, 0);
    do_reset();
    load_mode(14'h002F);
    #1 check(illegal_mode == 1, "R9 page interleaved", illegal_mode, 1);
    do_reset();
    load_mode(14'h0012);
    #1 check(illegal_mode == 1, "R9 CAS reserved", illegal_mode, 1);
    check(cas_latency == 0, "R7 reserved CAS", cas_latency, 0);
    do_reset();
    load_mode(14'h00A2);
    #1 check(illegal_mode == 1, "R9 op mode", illegal_mode, 1);
    do_reset();
    load_mode(14'h3C22);
    #1 check(illegal_mode == 0, "R9 high bits no effect", illegal_mode, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule